// File: doc/BRIEF.md
# Partitioned Coordination Register Unit with Fork/Join Scheduling

This block is a shared register file through which several processors coordinate parallel work without a central controller. The storage is cut into equal partitions, each describing one mounted process. Every processor port owns a small index register that names the partition it currently works in. A port can switch to another process just by rewriting its index, so several ports may share a partition (threads of one program) or sit in different ones (unrelated programs).

Each port issues one operation per cycle: plain reads and writes, an atomic fetch-and-increment, and three scheduling operations. A spawn queues a work descriptor in the partition's circular dispatch queue and raises the partition's active-thread count. A dispatch hands the oldest queued descriptor to a free processor, or reports that no work is waiting. A join lowers the active-thread count and tells the caller whether it was the last thread out, so exactly one processor carries on with the sequential code. Conflicting accesses in the same cycle are serialised by port number; a losing port is stalled and holds its request.

Operation codes on `req_op` (3 bits per port): 0 idle, 1 get, 2 put, 3 increment, 4 spawn, 5 join, 6 dispatch, 7 select partition.

Top module: `comm_reg_unit`

## Requirements
- R1: Reset sets every port's partition index to 0, empties every dispatch queue, clears every active-thread count and drops all responses and stalls to 0.
- R2: An accepted get (code 1) returns the register at partition index * PART_REGS + local address with `resp_flag`=1; an accepted put (code 2) stores `req_wdata` there and answers with flag 1 and data 0.
- R3: An accepted increment (code 3) returns the old register value with flag 1 and stores the old value plus one, so two increments always add two.
- R4: Select partition (code 7) loads the port's index from `req_wdata` bits [log2(NPART)-1:0] and answers with flag 1; the same local address in different partitions names different registers.
- R5: Spawn (code 4) pushes `req_wdata` into the partition's dispatch queue and adds one to its active-thread count, answering with flag 1 and the new count; when the queue holds QDEPTH entries it answers with flag 0 and the unchanged count and alters nothing.
- R6: Dispatch (code 6) removes and returns the oldest queued entry with flag 1; on an empty queue it answers with flag 0 and data 0.
- R7: Join (code 5) lowers a nonzero active-thread count by one and returns the remaining count, with flag 1 only when that count reaches zero; on a zero count it answers flag 0, data 0 and leaves the count at zero.
- R8: A port is stalled only when a lower-numbered port requests, in the same cycle, the same physical register with a get/put/increment, or the same partition with a spawn/join/dispatch; port 0 never stalls, select-partition never stalls, and a stalled request has no effect.
- R9: `resp_valid` of a port is high in exactly the cycle after each accepted (requested and not stalled) operation, and `resp_flag` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Per-port request strobe |
| req_op | input | NPORT*3 | Per-port operation code |
| req_addr | input | NPORT*log2(PART_REGS) | Per-port local register address |
| req_wdata | input | NPORT*DW | Per-port write data, work descriptor or partition number |
| stall | output | NPORT | Request lost arbitration this cycle; hold and retry |
| resp_valid | output | NPORT | Response present, one cycle after acceptance |
| resp_flag | output | NPORT | Success / last-join / entry-present flag |
| resp_data | output | NPORT*DW | Per-port response data |

## Verification
On every cycle the assertions check the arbitration shape: port 0 and select-partition requests are never stalled, a stall always has a lower-numbered requester behind it, and responses appear exactly one cycle after acceptance with no stray flag. What a stall actually protects, namely atomic increments landing twice, queue order, the full-queue refusal, last-join detection and the isolation of partitions, depends on stored values and is shown only by the bench's directed sequences, including a reset in the middle of activity.

// File: rtl/cru_pkg.sv
package cru_pkg;
   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_GET    = 3'd1,
      OP_PUT    = 3'd2,
      OP_INC    = 3'd3,
      OP_SPAWN  = 3'd4,
      OP_JOIN   = 3'd5,
      OP_DISP   = 3'd6,
      OP_SETIDX = 3'd7
   } cru_op_e;

   function automatic logic is_reg_op(cru_op_e o);
      return (o == OP_GET) || (o == OP_PUT) || (o == OP_INC);
   endfunction

   function automatic logic is_sched_op(cru_op_e o);
      return (o == OP_SPAWN) || (o == OP_JOIN) || (o == OP_DISP);
   endfunction
endpackage

// File: rtl/cru_arbiter.sv
module cru_arbiter import cru_pkg::*; #(
   parameter int NPORT = 4,
   parameter int RAW   = 10,
   parameter int PW    = 3
) (
   input  logic [NPORT-1:0] vld,
   input  cru_op_e          op   [NPORT],
   input  logic [RAW-1:0]   phys [NPORT],
   output logic [NPORT-1:0] grant
);
   // Two requests clash on the same register (data class) or the same
   // partition (scheduling class); select/idle never clash.
   function automatic logic clash(cru_op_e oa, logic [RAW-1:0] pa,
                                  cru_op_e ob, logic [RAW-1:0] pb);
      logic same_reg, same_part;
      same_reg  = (pa == pb);
      same_part = (pa[RAW-1 -: PW] == pb[RAW-1 -: PW]);
      return (is_reg_op(oa) && is_reg_op(ob) && same_reg) ||
             (is_sched_op(oa) && is_sched_op(ob) && same_part);
   endfunction

   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         grant[p] = vld[p];
         for (int q = 0; q < NPORT; q++) begin
            if (q < p && vld[q] && clash(op[q], phys[q], op[p], phys[p]))
               grant[p] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/cru_regfile.sv
module cru_regfile #(
   parameter int NPORT = 4,
   parameter int NREG  = 1024,
   parameter int DW    = 64,
   parameter int RAW   = 10
) (
   input  logic             clk,
   input  logic [NPORT-1:0] we,
   input  logic [RAW-1:0]   addr  [NPORT],
   input  logic [DW-1:0]    wdata [NPORT],
   output logic [DW-1:0]    rdata [NPORT]
);
   logic [DW-1:0] mem [NREG];

   // The arbiter guarantees no two enabled writes share an address.
   always_ff @(posedge clk) begin
      for (int p = 0; p < NPORT; p++) begin
         if (we[p]) mem[addr[p]] <= wdata[p];
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      assign rdata[p] = mem[addr[p]];
   end
endmodule

// File: rtl/cru_sched_part.sv
module cru_sched_part import cru_pkg::*; #(
   parameter int DW     = 64,
   parameter int QDEPTH = 8,
   parameter int CNT_W  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  cru_op_e       op,
   input  logic [DW-1:0] wd,
   output logic          flag,
   output logic [DW-1:0] data
);
   localparam int QAW = $clog2(QDEPTH);

   logic [DW-1:0]    qmem [QDEPTH];
   logic [QAW-1:0]   head, tail;
   logic [QAW:0]     occ;
   logic [CNT_W-1:0] thr;
   logic             full, empty, cnt_max;
   logic             do_push, do_pop, do_dec;

   assign full    = (occ == (QAW+1)'(QDEPTH));
   assign empty   = (occ == '0);
   assign cnt_max = &thr;

   always_comb begin
      flag = 1'b0;
      data = '0;
      unique case (op)
         OP_SPAWN: begin
            flag = !full && !cnt_max;
            data = flag ? DW'(thr + CNT_W'(1)) : DW'(thr);
         end
         OP_DISP: begin
            flag = !empty;
            data = empty ? '0 : qmem[head];
         end
         OP_JOIN: begin
            flag = (thr == CNT_W'(1));
            data = (thr == '0) ? '0 : DW'(thr - CNT_W'(1));
         end
         default: ;
      endcase
   end

   assign do_push = act && (op == OP_SPAWN) && flag;
   assign do_pop  = act && (op == OP_DISP)  && flag;
   assign do_dec  = act && (op == OP_JOIN)  && (thr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
         thr  <= '0;
      end else begin
         if (do_push) begin
            tail <= tail + QAW'(1);
            thr  <= thr + CNT_W'(1);
         end
         if (do_dec) thr <= thr - CNT_W'(1);
         if (do_pop) head <= head + QAW'(1);
         if (do_push && !do_pop)      occ <= occ + (QAW+1)'(1);
         else if (do_pop && !do_push) occ <= occ - (QAW+1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) qmem[tail] <= wd;
   end
endmodule

// File: rtl/comm_reg_unit.sv
module comm_reg_unit import cru_pkg::*; #(
   parameter int NPORT     = 4,
   parameter int NPART     = 8,
   parameter int PART_REGS = 128,
   parameter int DW        = 64,
   parameter int QDEPTH    = 8,
   parameter int CNT_W     = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NPORT-1:0]                     req_valid,
   input  logic [NPORT*3-1:0]                   req_op,
   input  logic [NPORT*$clog2(PART_REGS)-1:0]   req_addr,
   input  logic [NPORT*DW-1:0]                  req_wdata,
   output logic [NPORT-1:0]                     stall,
   output logic [NPORT-1:0]                     resp_valid,
   output logic [NPORT-1:0]                     resp_flag,
   output logic [NPORT*DW-1:0]                  resp_data
);
   localparam int PW   = $clog2(NPART);
   localparam int AW   = $clog2(PART_REGS);
   localparam int RAW  = PW + AW;
   localparam int NREG = NPART * PART_REGS;

   // Elaboration-time parameter checks
   if (NPART < 2 || (NPART & (NPART - 1)) != 0) begin : g_chk_part
      $error("NPART must be a power of two of at least 2");
   end
   if (PART_REGS < 2 || (PART_REGS & (PART_REGS - 1)) != 0) begin : g_chk_regs
      $error("PART_REGS must be a power of two of at least 2");
   end
   if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0) begin : g_chk_q
      $error("QDEPTH must be a power of two of at least 2");
   end
   if (NPORT < 1 || NPORT >= NPART) begin : g_chk_port
      $error("NPORT must be at least 1 and below NPART");
   end
   if (CNT_W > DW || CNT_W <= $clog2(QDEPTH)) begin : g_chk_cnt
      $error("CNT_W must fit in DW and exceed the queue index width");
   end

   cru_op_e          op      [NPORT];
   logic [AW-1:0]    la      [NPORT];
   logic [DW-1:0]    wd      [NPORT];
   logic [RAW-1:0]   phys    [NPORT];
   logic [PW-1:0]    idx_q   [NPORT];
   logic [DW-1:0]    rd      [NPORT];
   logic [DW-1:0]    wv      [NPORT];
   logic [NPORT-1:0] we;
   logic [NPORT-1:0] grant;
   logic             rsp_f   [NPORT];
   logic [DW-1:0]    rsp_d   [NPORT];
   logic             part_flag [NPART];
   logic [DW-1:0]    part_data [NPART];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign op[p]   = cru_op_e'(req_op[p*3 +: 3]);
      assign la[p]   = req_addr[p*AW +: AW];
      assign wd[p]   = req_wdata[p*DW +: DW];
      assign phys[p] = {idx_q[p], la[p]};
   end

   cru_arbiter #(.NPORT(NPORT), .RAW(RAW), .PW(PW)) u_arb (
      .vld   (req_valid),
      .op    (op),
      .phys  (phys),
      .grant (grant)
   );

   assign stall = req_valid & ~grant;

   cru_regfile #(.NPORT(NPORT), .NREG(NREG), .DW(DW), .RAW(RAW)) u_rf (
      .clk   (clk),
      .we    (we),
      .addr  (phys),
      .wdata (wv),
      .rdata (rd)
   );

   // One scheduling controller per partition; at most one granted port
   // reaches each of them per cycle.
   for (genvar k = 0; k < NPART; k++) begin : g_part
      logic          act;
      cru_op_e       kop;
      logic [DW-1:0] kwd;
      logic          kflag;
      logic [DW-1:0] kdata;

      always_comb begin
         act = 1'b0;
         kop = OP_NOP;
         kwd = '0;
         for (int p = 0; p < NPORT; p++) begin
            if (grant[p] && is_sched_op(op[p]) && idx_q[p] == PW'(k)) begin
               act = 1'b1;
               kop = op[p];
               kwd = wd[p];
            end
         end
      end

      cru_sched_part #(.DW(DW), .QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_sp (
         .clk   (clk),
         .rst_n (rst_n),
         .act   (act),
         .op    (kop),
         .wd    (kwd),
         .flag  (kflag),
         .data  (kdata)
      );

      assign part_flag[k] = kflag;
      assign part_data[k] = kdata;
   end

   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         rsp_f[p] = 1'b0;
         rsp_d[p] = '0;
         we[p]    = 1'b0;
         wv[p]    = wd[p];
         unique case (op[p])
            OP_GET: begin
               rsp_f[p] = 1'b1;
               rsp_d[p] = rd[p];
            end
            OP_PUT: begin
               rsp_f[p] = 1'b1;
               we[p]    = grant[p];
            end
            OP_INC: begin
               rsp_f[p] = 1'b1;
               rsp_d[p] = rd[p];
               we[p]    = grant[p];
               wv[p]    = rd[p] + DW'(1);
            end
            OP_SPAWN, OP_JOIN, OP_DISP: begin
               rsp_f[p] = part_flag[idx_q[p]];
               rsp_d[p] = part_data[idx_q[p]];
            end
            OP_SETIDX: rsp_f[p] = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= '0;
         resp_flag  <= '0;
         resp_data  <= '0;
         for (int p = 0; p < NPORT; p++) idx_q[p] <= '0;
      end else begin
         resp_valid <= grant;
         for (int p = 0; p < NPORT; p++) begin
            resp_flag[p]           <= grant[p] & rsp_f[p];
            resp_data[p*DW +: DW]  <= grant[p] ? rsp_d[p] : '0;
            if (grant[p] && op[p] == OP_SETIDX) idx_q[p] <= wd[p][PW-1:0];
         end
      end
   end
endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
   parameter int NPORT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NPORT-1:0]   req_valid,
   input logic [NPORT*3-1:0] req_op,
   input logic [NPORT-1:0]   stall,
   input logic [NPORT-1:0]   resp_valid,
   input logic [NPORT-1:0]   resp_flag
);
   p_port0_never_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[0] |-> !stall[0]);

   for (genvar p = 0; p < NPORT; p++) begin : g_p
      p_select_never_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[p] && req_op[p*3 +: 3] == 3'd7) |-> !stall[p]);

      p_resp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[p] && !stall[p]) |=> resp_valid[p]);

      p_no_resp_without_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !(req_valid[p] && !stall[p]) |=> !resp_valid[p]);

      p_flag_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
         resp_flag[p] |-> resp_valid[p]);

      if (p > 0) begin : g_hi
         p_stall_has_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
            stall[p] |-> (req_valid[p] && (|(req_valid & NPORT'((1 << p) - 1)))));
      end
   end
endmodule

bind comm_reg_unit cru_checker #(.NPORT(NPORT)) i_cru_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .stall      (stall),
   .resp_valid (resp_valid),
   .resp_flag  (resp_flag)
);

// File: tb/test_comm_reg_unit.sv
`timescale 1ns/100ps
module test_comm_reg_unit;
   localparam int NP = 4;
   localparam int AW = 7;
   localparam int DW = 64;
   localparam int QD = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     req_valid = '0;
   logic [NP*3-1:0]   req_op = '0;
   logic [NP*AW-1:0]  req_addr = '0;
   logic [NP*DW-1:0]  req_wdata = '0;
   logic [NP-1:0]     stall, resp_valid, resp_flag;
   logic [NP*DW-1:0]  resp_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [NP-1:0]    st_s, rv_s, rf_s;
   logic [NP*DW-1:0] rd_s;

   always #2.5 clk = ~clk;

   comm_reg_unit i_comm_reg_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
      .resp_valid(resp_valid), .resp_flag(resp_flag), .resp_data(resp_data)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [6:0]  addr;
      logic [63:0] wd;
      logic        ef;
      logic [63:0] ed;
      logic [3:0]  tag;
   } vec_t;

   // Port 0 sequence, starting in partition 0 right after reset.
   localparam vec_t VT [19] = '{
      '{3'd2, 7'd5, 64'h1234, 1'b1, 64'h0,    4'd2},  // R2 put
      '{3'd1, 7'd5, 64'h0,    1'b1, 64'h1234, 4'd2},  // R2 get
      '{3'd3, 7'd5, 64'h0,    1'b1, 64'h1234, 4'd3},  // R3 inc returns old
      '{3'd1, 7'd5, 64'h0,    1'b1, 64'h1235, 4'd3},  // R3 stored +1
      '{3'd6, 7'd0, 64'h0,    1'b0, 64'h0,    4'd6},  // R6 empty dispatch
      '{3'd4, 7'd0, 64'hA0,   1'b1, 64'h1,    4'd5},  // R5 spawn
      '{3'd4, 7'd0, 64'hB0,   1'b1, 64'h2,    4'd5},  // R5 spawn
      '{3'd6, 7'd0, 64'h0,    1'b1, 64'hA0,   4'd6},  // R6 oldest first
      '{3'd6, 7'd0, 64'h0,    1'b1, 64'hB0,   4'd6},  // R6
      '{3'd5, 7'd0, 64'h0,    1'b0, 64'h1,    4'd7},  // R7 not last
      '{3'd5, 7'd0, 64'h0,    1'b1, 64'h0,    4'd7},  // R7 last
      '{3'd5, 7'd0, 64'h0,    1'b0, 64'h0,    4'd7},  // R7 zero count
      '{3'd7, 7'd0, 64'h3,    1'b1, 64'h0,    4'd4},  // R4 select 3
      '{3'd2, 7'd5, 64'h77,   1'b1, 64'h0,    4'd4},  // R4 put in part 3
      '{3'd7, 7'd0, 64'h0,    1'b1, 64'h0,    4'd4},  // R4 select 0
      '{3'd1, 7'd5, 64'h0,    1'b1, 64'h1235, 4'd4},  // R4 isolation
      '{3'd7, 7'd0, 64'h3,    1'b1, 64'h0,    4'd4},  // R4
      '{3'd1, 7'd5, 64'h0,    1'b1, 64'h77,   4'd4},  // R4
      '{3'd7, 7'd0, 64'h0,    1'b1, 64'h0,    4'd4}   // R4 back to 0
   };

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic set_req(int p, logic [2:0] o, logic [6:0] a, logic [63:0] d);
      req_valid[p]          = 1'b1;
      req_op[p*3 +: 3]      = o;
      req_addr[p*AW +: AW]  = a;
      req_wdata[p*DW +: DW] = d;
   endtask

   // Inputs are driven 2 ns after a rising edge; stall is read 1 ns later,
   // responses 2 ns after the next rising edge.
   task automatic fire();
      #1;
      st_s = stall;
      @(posedge clk);
      #2;
      rv_s = resp_valid;
      rf_s = resp_flag;
      rd_s = resp_data;
      req_valid = '0;
   endtask

   function automatic logic [63:0] dat(int p);
      return rd_s[p*DW +: DW];
   endfunction

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk("R1 resp_valid after reset", 64'(resp_valid), 64'h0);
      chk("R1 stall after reset", 64'(stall), 64'h0);

      // Table walk on port 0
      for (int i = 0; i < 19; i++) begin
         set_req(0, VT[i].op, VT[i].addr, VT[i].wd);
         fire();
         chk($sformatf("R%0d vec %0d stall", VT[i].tag, i), 64'(st_s[0]), 64'h0);
         chk($sformatf("R9 vec %0d resp_valid", i), 64'(rv_s), 64'h1);
         chk($sformatf("R%0d vec %0d flag", VT[i].tag, i), 64'(rf_s[0]), 64'(VT[i].ef));
         chk($sformatf("R%0d vec %0d data", VT[i].tag, i), dat(0), VT[i].ed);
      end

      // R8: two increments of one register; port 1 loses and retries
      set_req(0, 3'd3, 7'd5, 64'h0);
      set_req(1, 3'd3, 7'd5, 64'h0);
      fire();
      chk("R8 same-reg stall", 64'(st_s), 64'h2);
      chk("R9 only winner responds", 64'(rv_s), 64'h1);
      chk("R3 winner old value", dat(0), 64'h1235);
      set_req(1, 3'd3, 7'd5, 64'h0);
      fire();
      chk("R3 retry sees first increment", dat(1), 64'h1236);
      set_req(0, 3'd1, 7'd5, 64'h0);
      fire();
      chk("R3 two increments landed", dat(0), 64'h1237);

      // R8: four distinct registers in one cycle
      for (int p = 0; p < NP; p++) set_req(p, 3'd2, 7'(10 + p), 64'(16'hC0 + p));
      fire();
      chk("R8 distinct regs no stall", 64'(st_s), 64'h0);
      chk("R9 all respond", 64'(rv_s), 64'hF);
      set_req(3, 3'd1, 7'd10, 64'h0);
      fire();
      chk("R2 shared partition read", dat(3), 64'hC0);

      // R8: two spawns into one partition
      set_req(2, 3'd4, 7'd0, 64'h200);
      set_req(3, 3'd4, 7'd0, 64'h300);
      fire();
      chk("R8 same-partition stall", 64'(st_s), 64'h8);
      chk("R5 spawn count", dat(2), 64'h1);
      set_req(3, 3'd4, 7'd0, 64'h300);
      fire();
      chk("R5 second spawn count", dat(3), 64'h2);
      set_req(1, 3'd6, 7'd0, 64'h0);
      fire();
      chk("R6 dispatch first", dat(1), 64'h200);
      set_req(0, 3'd5, 7'd0, 64'h0);
      fire();
      chk("R7 join not last flag", 64'(rf_s[0]), 64'h0);
      set_req(1, 3'd5, 7'd0, 64'h0);
      fire();
      chk("R7 join last flag", 64'(rf_s[1]), 64'h1);
      set_req(2, 3'd6, 7'd0, 64'h0);
      fire();
      chk("R6 dispatch second", dat(2), 64'h300);

      // R5: queue fills at QD entries
      for (int i = 0; i < QD; i++) begin
         set_req(0, 3'd4, 7'd0, 64'(16'hE00 + i));
         fire();
      end
      chk("R5 last accepted count", dat(0), 64'(QD));
      set_req(0, 3'd4, 7'd0, 64'hDEAD);
      fire();
      chk("R5 full refuses flag", 64'(rf_s[0]), 64'h0);
      chk("R5 full keeps count", dat(0), 64'(QD));
      set_req(0, 3'd6, 7'd0, 64'h0);
      fire();
      chk("R6 full queue oldest", dat(0), 64'hE00);
      for (int i = 1; i < QD; i++) begin
         set_req(0, 3'd6, 7'd0, 64'h0);
         fire();
      end
      chk("R5 refused entry not queued", dat(0), 64'hE07);
      set_req(0, 3'd6, 7'd0, 64'h0);
      fire();
      chk("R6 drained queue", 64'(rf_s[0]), 64'h0);

      // R1: reset in the middle of activity
      set_req(1, 3'd7, 7'd0, 64'h5);
      fire();
      set_req(0, 3'd4, 7'd0, 64'h55);
      fire();
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      chk("R1 responses cleared", 64'(resp_valid), 64'h0);
      rst_n = 1'b1;
      set_req(1, 3'd1, 7'd5, 64'h0);
      fire();
      chk("R1 index back to partition 0", dat(1), 64'h1237);
      set_req(0, 3'd6, 7'd0, 64'h0);
      fire();
      chk("R1 queue emptied", 64'(rf_s[0]), 64'h0);
      set_req(0, 3'd5, 7'd0, 64'h0);
      fire();
      chk("R1 thread count zero", {63'h0, rf_s[0]} | dat(0), 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule